// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block lets a host drive a small word-organised three-wire serial EEPROM through two 16-bit registers instead of bit-banging the serial lines. The host writes an encoded command (a two-bit opcode above a six-bit word address) into the command register. The controller then produces the complete serial transaction on chip select, serial clock and data out, and samples data in. While the transaction runs, bit 15 of the command register reads as one.

A read puts the 16-bit word it fetched into the data register. A write takes its payload from the data register, so the host loads that register before it issues the write. Writes and erases keep the busy flag set until the device drives data in high to signal that programming is over. The other opcode-0 commands, such as write-enable (0x30) and write-disable (0x00), send only the nine-bit header. The serial clock runs at the system clock divided by twice `HALF_DIV`. Data in passes through a parameterised synchroniser before the controller uses it.

Top module: `eewire_ctrl`

## Requirements
- R1: After reset the command register reads 0x0000 (busy clear), the data register reads 0x0000, and chip select and serial clock are low.
- R2: A command write accepted while idle makes command bit 15 read as 1 from the next clock until the transaction ends.
- R3: Command bits 7:6 hold the opcode and bits 5:0 the word address. Every frame starts with a 1 start bit, then the two opcode bits, then the six address bits, each MSB first on data out.
- R4: Each serial bit is a low phase and then a high phase, each exactly `HALF_DIV` clocks long. The serial clock is high only while chip select is high, and data out never changes while the serial clock is high.
- R5: A read (opcode 2, command 0x80 + address) samples 16 data bits MSB first from data in at the end of each high phase after the address. The word lands in the data register, and busy lasts exactly 50×`HALF_DIV` clocks.
- R6: A write (opcode 1, command 0x40 + address) sends the 16 data-register bits MSB first after the address.
- R7: After a write or erase (opcode 3, command 0xC0 + address) frame, chip select goes low for `HALF_DIV` clocks and then high again. Busy stays set until data in reads high, and chip select drops with busy.
- R8: An opcode-0 command (write-enable 0x30, write-disable 0x00) sends only the nine header bits, waits for no ready, and keeps busy for exactly 18×`HALF_DIV` clocks.
- R9: Writes to the command register or the data register while busy is set are ignored.
- R10: Command bits 7:0 read back the last accepted command, and bits 14:8 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 1 | Register select: 0 command, 1 data |
| host_wdata | input | 16 | Host write value |
| cmd_rdata | output | 16 | Command register: bit 15 busy, bits 7:0 last command |
| data_rdata | output | 16 | Data register |
| ee_cs | output | 1 | Serial chip select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data towards the device |
| ee_do | input | 1 | Serial data / ready from the device |

## Verification
The bench attaches a behavioural EEPROM with a write-enable latch and a programming delay. It issues write-enable, writes, erases, reads and write-disable, and compares each result with a mirror array. Directed words 0x8001 and 0x0000 at addresses 0 and 63 separate bit-order and end-of-address errors from plain data errors. Seeded random address/data pairs, read back either at once or at another address, catch address decoding that drifts. The bench times busy for each opcode class, which tells the no-data, read and ready-polled frame lengths apart. Commands and data written during an erase show whether the busy guard holds. A monitor measures every serial-clock phase and watches data out during high phases.

// File: rtl/eewire_pkg.sv
package eewire_pkg;

  typedef enum logic [1:0] {
    OP_MISC  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_ERASE = 2'd3
  } ee_op_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_POLL
  } ee_state_t;

  // opcode classes carrying a 16-bit payload after the address
  function automatic logic carries_data(ee_op_t op);
    return (op == OP_READ) || (op == OP_WRITE);
  endfunction

  // opcode classes that start internal programming in the device
  function automatic logic needs_poll(ee_op_t op);
    return (op == OP_WRITE) || (op == OP_ERASE);
  endfunction

  // number of serial bits in a frame: start + opcode + address [+ data]
  function automatic int unsigned frame_len(ee_op_t op, int unsigned aw, int unsigned dw);
    return 3 + aw + (carries_data(op) ? dw : 0);
  endfunction

endpackage

// File: rtl/eewire_sync.sv
module eewire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_ff
      logic [STAGES-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n) r <= '0;
        else        r <= (r << 1) | STAGES'(d);
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/eewire_clkdiv.sv
module eewire_clkdiv #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_end
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign phase_end = run && (cnt == LAST);
endmodule

// File: rtl/eewire_shift.sv
module eewire_shift
  import eewire_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  ee_op_t            load_op,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              adv,
  input  logic              sample,
  input  logic              din,
  output logic              dout,
  output logic [DATA_W-1:0] rx_next
);
  localparam int FRAME_W = 3 + ADDR_W + DATA_W;

  logic [FRAME_W-1:0] tx;
  logic [DATA_W-1:0]  rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx <= '0;
      rx <= '0;
    end else begin
      if (load)     tx <= {1'b1, load_op, load_addr, load_data};
      else if (adv) tx <= tx << 1;
      if (sample)   rx <= rx_next;
    end
  end

  assign dout    = tx[FRAME_W-1];
  assign rx_next = {rx[DATA_W-2:0], din};
endmodule

// File: rtl/eewire_seq.sv
module eewire_seq
  import eewire_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  ee_op_t    start_op,
  input  logic      phase_end,
  input  logic      din,
  output ee_state_t state,
  output logic      cs,
  output logic      sk,
  output logic      shift_adv,
  output logic      sample_en,
  output logic      frame_done,
  output logic      read_done,
  output logic      poll_ready
);
  localparam int HDR_W   = 3 + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [CNT_W-1:0] bidx;
  logic [CNT_W-1:0] len_q;
  ee_op_t           op_q;
  logic             last_bit;

  assign last_bit   = (bidx == len_q - CNT_W'(1));
  assign shift_adv  = (state == ST_SHIFT) && phase_end && sk;
  assign sample_en  = shift_adv && (op_q == OP_READ) && (bidx >= CNT_W'(HDR_W));
  assign frame_done = shift_adv && last_bit;
  assign read_done  = frame_done && (op_q == OP_READ);
  assign poll_ready = (state == ST_POLL) && din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cs    <= 1'b0;
      sk    <= 1'b0;
      bidx  <= '0;
      len_q <= '0;
      op_q  <= OP_MISC;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_SHIFT;
            cs    <= 1'b1;
            sk    <= 1'b0;
            bidx  <= '0;
            op_q  <= start_op;
            len_q <= CNT_W'(frame_len(start_op, ADDR_W, DATA_W));
          end
        end
        ST_SHIFT: begin
          if (phase_end) begin
            if (!sk) begin
              sk <= 1'b1;
            end else begin
              sk <= 1'b0;
              if (last_bit) begin
                cs    <= 1'b0;
                state <= needs_poll(op_q) ? ST_GAP : ST_IDLE;
              end else begin
                bidx <= bidx + 1'b1;
              end
            end
          end
        end
        ST_GAP: begin
          if (phase_end) begin
            state <= ST_POLL;
            cs    <= 1'b1;
          end
        end
        ST_POLL: begin
          if (din) begin
            state <= ST_IDLE;
            cs    <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eewire_ctrl.sv
module eewire_ctrl
  import eewire_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [15:0]       cmd_rdata,
  output logic [DATA_W-1:0] data_rdata,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int CMD_W = ADDR_W + 2;
  localparam int PAD_W = 15 - CMD_W;

  ee_state_t         state;
  logic              busy;
  logic              cmd_accept;
  logic              data_load;
  logic              phase_end;
  logic              shift_adv;
  logic              sample_en;
  logic              frame_done;
  logic              read_done;
  logic              poll_ready;
  logic              do_s;
  logic [DATA_W-1:0] rx_next;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] data_q;
  ee_op_t            new_op;

  assign busy       = (state != ST_IDLE);
  assign cmd_accept = host_wr && !host_sel && !busy;
  assign data_load  = host_wr && host_sel && !busy;
  assign new_op     = ee_op_t'(host_wdata[CMD_W-1:ADDR_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_accept) cmd_q <= host_wdata[CMD_W-1:0];
      if (read_done)      data_q <= rx_next;
      else if (data_load) data_q <= host_wdata;
    end
  end

  assign cmd_rdata  = {busy, {PAD_W{1'b0}}, cmd_q};
  assign data_rdata = data_q;

  eewire_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ee_do), .q(do_s)
  );

  eewire_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .phase_end(phase_end)
  );

  eewire_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(cmd_accept), .load_op(new_op),
    .load_addr(host_wdata[ADDR_W-1:0]), .load_data(data_q),
    .adv(shift_adv), .sample(sample_en), .din(do_s),
    .dout(ee_di), .rx_next(rx_next)
  );

  eewire_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(cmd_accept), .start_op(new_op),
    .phase_end(phase_end), .din(do_s),
    .state(state), .cs(ee_cs), .sk(ee_sk),
    .shift_adv(shift_adv), .sample_en(sample_en),
    .frame_done(frame_done), .read_done(read_done),
    .poll_ready(poll_ready)
  );
endmodule

// File: rtl/eewire_chk.sv
module eewire_chk #(
  parameter int HALF_DIV = 4,
  parameter int LOW_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             cmd_accept,
  input logic             poll_ready,
  input logic             host_wr,
  input logic             host_sel,
  input logic [LOW_W-1:0] cmd_low,
  input logic             ee_cs,
  input logic             ee_sk,
  input logic             ee_di
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     hi_cnt <= '0;
    else if (ee_sk) hi_cnt <= hi_cnt + 1'b1;
    else            hi_cnt <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> busy);

  p_sk_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  p_di_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> $stable(ee_di));

  p_sk_high_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_sk) |-> (hi_cnt == 16'(HALF_DIV)));

  p_cs_rise_low_sk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> !ee_sk);

  p_poll_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ready |=> (!busy && !ee_cs));

  p_ignore_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr && !host_sel) |=> $stable(cmd_low));
endmodule

bind eewire_ctrl eewire_chk #(.HALF_DIV(HALF_DIV), .LOW_W(ADDR_W + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_accept(cmd_accept),
  .poll_ready(poll_ready), .host_wr(host_wr), .host_sel(host_sel),
  .cmd_low(cmd_q), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/eewire_ctrl_bench.sv
`timescale 1ns/1ps
module eewire_ctrl_bench;
  localparam int H    = 4;
  localparam int PROG = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_sel = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] cmd_rdata, data_rdata;
  logic        ee_cs, ee_sk, ee_di, ee_do;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  eewire_ctrl #(.ADDR_W(6), .DATA_W(16), .HALF_DIV(H), .SYNC_STAGES(2)) u_eewire_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .cmd_rdata(cmd_rdata), .data_rdata(data_rdata),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  // ---------------- behavioural serial EEPROM ----------------
  logic [15:0] mem [64];
  logic        sk_q, cs_q, reading, do_q, wen, m_start;
  logic [24:0] sr;
  logic [1:0]  m_op;
  logic [5:0]  m_addr, pend_addr;
  logic [15:0] m_wdata, pend_data, rd_sr;
  int          bitcnt, prog_cnt, pend;

  function automatic logic [15:0] init_word(int i);
    return 16'(i * 16'h0101) ^ 16'h5A3C;
  endfunction

  assign ee_do = ee_cs ? ((prog_cnt != 0) ? 1'b0 : (reading ? do_q : 1'b1)) : 1'b0;

  always @(posedge clk) begin : model
    int n;
    logic [24:0] s;
    sk_q <= ee_sk;
    cs_q <= ee_cs;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
      bitcnt <= 0; prog_cnt <= 0; pend <= 0; reading <= 1'b0; do_q <= 1'b0;
      wen <= 1'b0; sr <= '0; m_op <= '0; m_addr <= '0; m_start <= 1'b0;
      m_wdata <= '0; rd_sr <= '0; pend_addr <= '0; pend_data <= '0;
    end else begin
      if (prog_cnt > 0) prog_cnt <= prog_cnt - 1;
      if (cs_q && !ee_cs) begin
        if (pend == 1) mem[pend_addr] <= pend_data;
        else if (pend == 2) mem[pend_addr] <= 16'hFFFF;
        if (pend != 0) prog_cnt <= PROG;
        pend <= 0; bitcnt <= 0; reading <= 1'b0;
      end else if (ee_cs && ee_sk && !sk_q) begin
        n = bitcnt + 1;
        s = {sr[23:0], ee_di};
        sr <= s;
        bitcnt <= n;
        if (n == 9) begin
          m_start <= s[8]; m_op <= s[7:6]; m_addr <= s[5:0];
          case (s[7:6])
            2'd2: begin reading <= 1'b1; rd_sr <= mem[s[5:0]]; end
            2'd0: begin
              if (s[5:4] == 2'b11) wen <= 1'b1;
              else if (s[5:4] == 2'b00) wen <= 1'b0;
            end
            2'd3: if (wen) begin pend <= 2; pend_addr <= s[5:0]; end
            default: ;
          endcase
        end
        if (n == 25 && m_op == 2'd1) begin
          m_wdata <= s[15:0];
          if (wen) begin pend <= 1; pend_addr <= m_addr; pend_data <= s[15:0]; end
        end
      end else if (ee_cs && !ee_sk && sk_q && reading) begin
        do_q  <= rd_sr[15];
        rd_sr <= {rd_sr[14:0], 1'b0};
      end
    end
  end

  // ---------------- serial timing monitor ----------------
  int hi_run = 0, lo_run = 0, bad_sk = 0, di_bad = 0;
  logic prev_sk = 1'b0, prev_di = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_sk) begin
        if (prev_sk && ee_di != prev_di) di_bad++;
        hi_run++;
      end
      if (!ee_sk && prev_sk) begin
        if (hi_run != H) bad_sk++;
        hi_run = 0;
      end
      if (ee_sk && !prev_sk) begin
        if (lo_run != H) bad_sk++;
        lo_run = 0;
      end
      if (ee_cs && !ee_sk) lo_run++;
      if (!ee_cs) lo_run = 0;
      if (ee_sk && !ee_cs) bad_sk++;
    end
    prev_sk = ee_sk;
    prev_di = ee_di;
  end

  // ---------------- helpers ----------------
  logic [15:0] exp_mem [64];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_put(input bit sel, input logic [15:0] v);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wait_idle(inout int cyc);
    while (cmd_rdata[15] && cyc < 5000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic run_cmd(input logic [15:0] v, output int cyc);
    host_put(1'b0, v);
    cyc = 0;
    wait_idle(cyc);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [15:0] keep;
    void'($urandom(32'd1357));
    for (int i = 0; i < 64; i++) exp_mem[i] = init_word(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_rdata == 16'h0000, "R1 cmd reg", 32'(cmd_rdata), 32'h0);
    chk(data_rdata == 16'h0000, "R1 data reg", 32'(data_rdata), 32'h0);
    chk(!ee_cs && !ee_sk, "R1 serial idle", {30'd0, ee_cs, ee_sk}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // write-enable: header only
    host_put(1'b0, 16'h0030);
    chk(cmd_rdata[15] == 1'b1, "R2 busy after accept", 32'(cmd_rdata[15]), 32'h1);
    cyc = 1;
    @(negedge clk);
    wait_idle(cyc);
    chk(cyc == 18 * H, "R8 enable frame length", 32'(cyc), 32'(18 * H));
    chk({m_start, m_op, m_addr} == 9'h130, "R3 header bits", 32'({m_start, m_op, m_addr}), 32'h130);
    chk(cmd_rdata == 16'h0030, "R10 readback", 32'(cmd_rdata), 32'h30);

    // write to top address
    host_put(1'b1, 16'h1234);
    chk(data_rdata == 16'h1234, "R6 data load", 32'(data_rdata), 32'h1234);
    run_cmd(16'h007F, cyc);
    exp_mem[63] = 16'h1234;
    chk(cyc >= 50 * H + PROG && cyc <= 51 * H + PROG + 8, "R7 write ready wait", 32'(cyc), 32'(50 * H + PROG));
    chk(m_wdata == 16'h1234, "R6 serial payload", 32'(m_wdata), 32'h1234);
    chk({m_start, m_op, m_addr} == 9'h17F, "R3 write header", 32'({m_start, m_op, m_addr}), 32'h17F);

    run_cmd(16'h00BF, cyc);
    chk(cyc == 50 * H, "R5 read frame length", 32'(cyc), 32'(50 * H));
    chk(data_rdata == 16'h1234, "R5 read word", 32'(data_rdata), 32'h1234);
    run_cmd(16'h0080, cyc);
    chk(data_rdata == exp_mem[0], "R5 read addr 0", 32'(data_rdata), 32'(exp_mem[0]));
    keep = data_rdata;

    // erase with host writes during busy
    host_put(1'b0, 16'h00C9);
    cyc = 1;
    host_put(1'b1, 16'hBEEF);
    host_put(1'b0, 16'h0085);
    cyc += 4;
    wait_idle(cyc);
    exp_mem[9] = 16'hFFFF;
    chk(data_rdata == keep, "R9 data write ignored", 32'(data_rdata), 32'(keep));
    chk(cmd_rdata == 16'h00C9, "R9 cmd write ignored", 32'(cmd_rdata), 32'hC9);
    chk(cyc >= 18 * H + PROG && cyc <= 19 * H + PROG + 8, "R7 erase ready wait", 32'(cyc), 32'(18 * H + PROG));
    run_cmd(16'h0089, cyc);
    chk(data_rdata == 16'hFFFF, "R7 erased word", 32'(data_rdata), 32'hFFFF);

    // directed edge patterns
    for (int k = 0; k < 2; k++) begin
      logic [5:0]  a;
      logic [15:0] d;
      a = (k == 0) ? 6'd0 : 6'd63;
      d = (k == 0) ? 16'h8001 : 16'h0000;
      host_put(1'b1, d);
      run_cmd(16'h0040 | 16'(a), cyc);
      exp_mem[a] = d;
      run_cmd(16'h0080 | 16'(a), cyc);
      chk(data_rdata == d, "R6 directed pattern", 32'(data_rdata), 32'(d));
    end

    // seeded random traffic
    for (int i = 0; i < 14; i++) begin
      logic [5:0]  a, b;
      logic [15:0] d;
      a = 6'($urandom % 64);
      d = 16'($urandom);
      b = (i % 3 == 0) ? a : 6'($urandom % 64);
      host_put(1'b1, d);
      run_cmd(16'h0040 | 16'(a), cyc);
      exp_mem[a] = d;
      run_cmd(16'h0080 | 16'(b), cyc);
      chk(data_rdata == exp_mem[b], "R5 random readback", 32'(data_rdata), 32'(exp_mem[b]));
    end

    // write-disable then a write that must not program
    run_cmd(16'h0000, cyc);
    chk(cyc == 18 * H, "R8 disable frame length", 32'(cyc), 32'(18 * H));
    host_put(1'b1, 16'h55AA);
    run_cmd(16'h0043, cyc);
    chk(cyc <= 51 * H + 8, "R7 ready at once", 32'(cyc), 32'(51 * H));
    run_cmd(16'h0083, cyc);
    chk(data_rdata == exp_mem[3], "R8 disabled write", 32'(data_rdata), 32'(exp_mem[3]));

    chk(bad_sk == 0, "R4 phase lengths", 32'(bad_sk), 32'h0);
    chk(di_bad == 0, "R4 data stable high", 32'(di_bad), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule